// File: doc/BRIEF.md
# Universal Shift/Storage Register with Shared Bus

A parameterised register (eight bits by default) that holds its contents, shifts toward the high end, shifts toward the low end, or loads a whole word from a shared parallel bus. All state changes, including clearing, happen on the rising clock edge. The shared bus is modelled as three pieces: an input vector carrying data into the block, an output vector carrying the stored word, and a drive-enable flag that tells the surrounding pad logic when to turn the bus drivers on.

Two serial taps always show the lowest and highest stored bits, whatever the bus enables are doing. A tap can feed the serial input of the next register, so several blocks can be chained into one longer shift register. The bus is driven only when two active-low enables are both asserted. During a parallel load the drivers are always off, so the bus acts purely as an input.

Top module: `univ_shift_reg`

## Requirements
- R1: With `mode_sel` = 2'b00 (hold) and `rst_n` high at a rising edge, the stored word does not change.
- R2: With `mode_sel` = 2'b01 (shift up) at a rising edge, `ser_in_up` enters bit 0 and each bit n moves to bit n+1.
- R3: With `mode_sel` = 2'b10 (shift down) at a rising edge, `ser_in_down` enters bit WIDTH-1 and each bit n moves to bit n-1.
- R4: With `mode_sel` = 2'b11 (load) at a rising edge, the stored word becomes `bus_in`.
- R5: When `rst_n` is low at a rising edge, every bit clears to zero whatever the mode. A low pulse on `rst_n` that ends before the next edge has no effect.
- R6: `bus_drive` is high only when `oe_a_n` and `oe_b_n` are both low and `mode_sel` is not 2'b11. While it is high, `bus_out` equals the stored word.
- R7: `tap_lsb` and `tap_msb` always show stored bit 0 and bit WIDTH-1, including when `bus_drive` is low.
- R8: With `tap_msb` of one block wired to `ser_in_up` of a second, and `tap_lsb` of the second wired to `ser_in_down` of the first, the pair shifts as one 2*WIDTH-bit register in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_up | input | 1 | Serial bit entering bit 0 on an up shift |
| ser_in_down | input | 1 | Serial bit entering bit WIDTH-1 on a down shift |
| oe_a_n | input | 1 | Bus output enable A, active low |
| oe_b_n | input | 1 | Bus output enable B, active low |
| bus_in | input | WIDTH | Value sampled from the shared bus |
| bus_out | output | WIDTH | Stored word presented to the bus drivers |
| bus_drive | output | 1 | Turns the bus drivers on |
| tap_lsb | output | 1 | Stored bit 0, always valid |
| tap_msb | output | 1 | Stored bit WIDTH-1, always valid |

## Verification
Two blocks are chained as a 16-bit pair and driven with a seeded random mix of modes, serial bits, enables and occasional clears. A 16-bit bench model predicts every step, so a wrong shift direction, a lost serial bit or a swapped mode code shows up as a mismatch. Directed runs load a known pattern and shift it the full pair length each way. That separates a correct chain from one that drops or duplicates bits at the seam between the blocks. A short clear pulse placed between edges shows whether the clear is truly synchronous. Enable combinations, tried in load mode and in other modes, show whether the bus drivers are forced off during a load.

// File: rtl/usr_pkg.sv
// Shared encodings for the universal shift register.
// Assumes a two-bit mode code; the values are fixed by the block's pin-level behaviour.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_next_state.sv
// Next-value selector for the register bits.
// Assumes WIDTH >= 2. A low clear overrides every mode.
module usr_next_state
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_q,
    input  logic [1:0]       mode_sel,
    input  logic             clr_n,
    input  logic             ser_up,
    input  logic             ser_down,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] nxt_q
);
    usr_mode_e mode;
    assign mode = usr_mode_e'(mode_sel);

    // Pick the value the register takes at the next edge.
    always_comb begin
        if (!clr_n) begin
            nxt_q = '0;
        end else begin
            unique case (mode)
                MODE_HOLD: nxt_q = cur_q;
                MODE_UP:   nxt_q = {cur_q[WIDTH-2:0], ser_up};
                MODE_DOWN: nxt_q = {ser_down, cur_q[WIDTH-1:1]};
                MODE_LOAD: nxt_q = par_in;
                default:   nxt_q = cur_q;
            endcase
        end
    end
endmodule

// File: rtl/usr_bus_ctrl.sv
// Bus driver enable for the shared parallel lines.
// Assumes both enables are active low. The load mode always releases the bus.
module usr_bus_ctrl
    import usr_pkg::*;
(
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    input  logic [1:0] mode_sel,
    output logic       drive
);
    logic loading;

    // Detect the mode that turns the bus into an input.
    always_comb loading = (usr_mode_e'(mode_sel) == MODE_LOAD);

    // Drive only when both enables are asserted and no load is selected.
    always_comb drive = !oe_a_n && !oe_b_n && !loading;
endmodule

// File: rtl/univ_shift_reg.sv
// Universal shift/storage register with a shared parallel bus.
// Assumes a single clock and a synchronous active-low clear. The bus is split into
// in, out and drive-enable; pad tristate logic lives outside this block.
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_in_up,
    input  logic             ser_in_down,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_drive,
    output logic             tap_lsb,
    output logic             tap_msb
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] store_d;

    usr_next_state #(.WIDTH(WIDTH)) u_next (
        .cur_q    (store_q),
        .mode_sel (mode_sel),
        .clr_n    (rst_n),
        .ser_up   (ser_in_up),
        .ser_down (ser_in_down),
        .par_in   (bus_in),
        .nxt_q    (store_d)
    );

    usr_bus_ctrl u_bus (
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .mode_sel (mode_sel),
        .drive    (bus_drive)
    );

    // Register the selected next value on each rising edge.
    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    assign bus_out = store_q;
    assign tap_lsb = store_q[0];
    assign tap_msb = store_q[MSB];

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> (store_q == $past(store_q)));

    assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |=> (store_q == {$past(store_q[MSB-1:0]), $past(ser_in_up)}));

    assert_shift_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10) |=> (store_q == {$past(ser_in_down), $past(store_q[MSB:1])}));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |=> (store_q == $past(bus_in)));

    assert_clear_R5: assert property (@(posedge clk)
        (!rst_n) |=> (store_q == '0));

    assert_load_releases_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |-> !bus_drive);

    assert_enable_gates_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !bus_drive);

    assert_tap_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |=> (tap_lsb == $past(ser_in_up)));
endmodule

// File: tb/sim_univ_shift_reg.sv
module sim_univ_shift_reg;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic ser_up0 = 1'b0;
    logic ser_down1 = 1'b0;
    logic oe_a_n = 1'b1;
    logic oe_b_n = 1'b1;
    logic [W-1:0] bin0 = '0, bin1 = '0;
    logic [W-1:0] bout0, bout1;
    logic drv0, drv1;
    logic lsb0, msb0, lsb1, msb1;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [2*W-1:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    univ_shift_reg #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .ser_in_up(ser_up0), .ser_in_down(lsb1),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bin0),
        .bus_out(bout0), .bus_drive(drv0), .tap_lsb(lsb0), .tap_msb(msb0));

    univ_shift_reg #(.WIDTH(W)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .ser_in_up(msb0), .ser_in_down(ser_down1),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bin1),
        .bus_out(bout1), .bus_drive(drv1), .tap_lsb(lsb1), .tap_msb(msb1));

    function automatic logic [2*W-1:0] predict(logic [2*W-1:0] cur, logic clr_n,
            logic [1:0] m, logic su, logic sd, logic [W-1:0] b0, logic [W-1:0] b1);
        if (!clr_n) return '0;
        case (m)
            2'b00: return cur;
            2'b01: return {cur[2*W-2:0], su};
            2'b10: return {sd, cur[2*W-1:1]};
            default: return {b1, b0};
        endcase
    endfunction

    function automatic string mode_tag(logic clr_n, logic [1:0] m);
        if (!clr_n) return "R5";
        case (m)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive inputs, check bus enable, advance one edge, check state.
    task automatic step(logic clr_n, logic [1:0] m, logic su, logic sd,
                        logic oa, logic ob, logic [W-1:0] b0, logic [W-1:0] b1, string tag);
        logic exp_drv;
        rst_n = clr_n; mode_sel = m; ser_up0 = su; ser_down1 = sd;
        oe_a_n = oa; oe_b_n = ob; bin0 = b0; bin1 = b1;
        #1;
        exp_drv = !oa && !ob && (m != 2'b11);
        check(drv0 == exp_drv && drv1 == exp_drv, "R6 drive", {30'd0, drv1, drv0}, {30'd0, exp_drv, exp_drv});
        if (exp_drv)
            check({bout1, bout0} == model, "R6 bus_out", {16'd0, bout1, bout0}, {16'd0, model});
        model = predict(model, clr_n, m, su, sd, b0, b1);
        @(posedge clk);
        @(negedge clk);
        check({bout1, bout0} == model, tag, {16'd0, bout1, bout0}, {16'd0, model});
        check({msb1, lsb1, msb0, lsb0} == {model[15], model[8], model[7], model[0]}, "R7 taps",
              {28'd0, msb1, lsb1, msb0, lsb0}, {28'd0, model[15], model[8], model[7], model[0]});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        model = '0;
        @(negedge clk);
        step(1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, '1, '1, "R5 reset state");
        step(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, '1, '1, "R5 clear beats load");

        // Cascade up: load a pattern, push 16 bits through the pair (R8).
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 8'hA5, "R4 load");
        for (int i = 0; i < 16; i++)
            step(1'b1, 2'b01, i[0], 1'b0, 1'b0, 1'b0, '0, '0, "R8 up chain");
        check({bout1, bout0} == 16'h5555, "R8 up chain full", {16'd0, bout1, bout0}, 32'h5555);

        // Cascade down, symmetric direction (R8).
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 8'h7E, "R4 load released");
        for (int i = 0; i < 16; i++)
            step(1'b1, 2'b10, 1'b0, ~i[1], 1'b0, 1'b1, '0, '0, "R8 down chain");
        check({bout1, bout0} == 16'h3333, "R8 down chain full", {16'd0, bout1, bout0}, 32'h3333);

        // Hold with every enable combination, bus in busy (R1, R6).
        for (int e = 0; e < 4; e++)
            step(1'b1, 2'b00, 1'b1, 1'b1, e[0], e[1], 8'hFF, 8'h00, "R1 hold");

        // Clear pulse that ends before the edge is ignored (R5).
        rst_n = 1'b0; #1; rst_n = 1'b1;
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R5 glitch ignored");

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            r = $urandom;
            step((r[4:0] != 5'd0), r[6:5], r[7], r[8], r[9] & r[10], r[11] & r[12],
                 r[20:13], r[28:21], mode_tag((r[4:0] != 5'd0), r[6:5]));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule